// File: doc/BRIEF.md
# Serial control-register receiver for an audio tone/volume processor

This block is the write path into the settings of an analogue audio processor. A host drives a two-wire serial bus (I2C, write direction only). The block samples both bus lines with its own system clock and cleans them before use. It recognises bus conditions, accepts one fixed device address, and takes a function-select byte followed by any number of setting bytes. It acknowledges every byte it accepts by pulling the data line low. Each stored setting appears as a parallel output, ready to steer the analogue switches and resistor networks.

The select byte can do one of two things. It can pin every following byte to a single function register, so the host can update one setting repeatedly in one transfer. Or it can start a pointer that advances by one after each byte, so the host can load the whole bank in one burst. Some function codes are reserved, and codes past the last register are skipped. Every register has its own power-on value. Each accepted store is announced by a one-cycle pulse carrying the register code.

Top module: `tone_ctl_i2c_regs`

## Requirements
- R1: While reset is held and after it is released, the outputs are: att_q 0x7F (maximum input attenuation), mode_q 0x6E (surround off, fixed output, maximum effect attenuation), phase_q 0x00, bass_q 0x0F, treble_q 0x7E (flat), spk_l_q and spk_r_q 0x78 (muted), src_q 0x00 (input 1), sda_pull_n 1, upd_stb 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a START, the first byte (8 bits, MSB first) equal to 0x80 is acknowledged: sda_pull_n goes low from the falling SCL edge of bit 8 until the falling SCL edge of the ninth clock.
- R3: Any other first byte, including 0x81, gets no acknowledge. All later bytes are ignored and not acknowledged until the next START.
- R4: The second byte is acknowledged. Its bit 7 selects auto-increment (1) or single-register mode (0). Bits 3:0 select the register code. Bits 6:4 have no effect.
- R5: In single-register mode, every data byte up to STOP or START is stored in the selected register, so the last byte wins.
- R6: In auto-increment mode, the first data byte goes to the selected code and each later byte goes to the next code. Register codes are: 0 att_q, 1 mode_q, 2 phase_q, 3 bass_q, 4 treble_q, 5 spk_l_q, 6 spk_r_q, 9 src_q.
- R7: Data bytes aimed at codes 10 to 15 are acknowledged and discarded. After code 15 the pointer wraps to code 0.
- R8: Data bytes aimed at the reserved codes 7 and 8 are acknowledged but change no output and raise no strobe.
- R9: A stored byte appears on its output in the same cycle that upd_stb pulses for exactly one cycle, with upd_idx equal to the register code. This happens on the rising SCL edge of that byte's acknowledge clock.
- R10: A pulse on SCL or SDA that lasts fewer than FILT system clocks (default 3) has no effect on bit reception or on START/STOP detection.
- R11: A START in the middle of a transfer (repeated START) abandons the transfer and begins address matching again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND with this block's pull-down) |
| sda_pull_n | output | 1 | Open-drain data drive; 0 pulls the data line low |
| upd_stb | output | 1 | One-cycle pulse when a register is stored |
| upd_idx | output | 4 | Code of the register stored with upd_stb |
| att_q | output | 8 | Input attenuation setting (code 0) |
| mode_q | output | 8 | Surround, output and effect setting (code 1) |
| phase_q | output | 8 | Phase-shifter resistor setting (code 2) |
| bass_q | output | 8 | Bass setting (code 3) |
| treble_q | output | 8 | Treble setting (code 4) |
| spk_l_q | output | 8 | Left speaker attenuation (code 5) |
| spk_r_q | output | 8 | Right speaker attenuation (code 6) |
| src_q | output | 8 | Input selector setting (code 9) |

## Verification
On the acknowledge clock of a byte aimed at code 15 in auto-increment mode, two things happen in the same cycle: the byte is discarded and the pointer wraps to code 0. A burst that starts at select byte 0x8E and carries four bytes provokes this. The behavioural model in the bench expects no strobe for codes 14 and 15, then stores to codes 0 and 1. A burst starting at 0x86 makes discard and advance coincide on the reserved codes in the same way, and it must land its last byte on code 9. The outputs, the strobe and the acknowledge line are compared against the model on every clock.

// File: rtl/tone_ctl_i2c_regs.sv
module tone_ctl_i2c_regs #(
  parameter logic [6:0] DEV_ADDR   = 7'h40,
  parameter int         FILT       = 3,
  parameter logic [7:0] ATT_RST    = 8'h7F,
  parameter logic [7:0] MODE_RST   = 8'h6E,
  parameter logic [7:0] PHASE_RST  = 8'h00,
  parameter logic [7:0] BASS_RST   = 8'h0F,
  parameter logic [7:0] TREBLE_RST = 8'h7E,
  parameter logic [7:0] SPK_RST    = 8'h78,
  parameter logic [7:0] SRC_RST    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_n,
  output logic       upd_stb,
  output logic [3:0] upd_idx,
  output logic [7:0] att_q,
  output logic [7:0] mode_q,
  output logic [7:0] phase_q,
  output logic [7:0] bass_q,
  output logic [7:0] treble_q,
  output logic [7:0] spk_l_q,
  output logic [7:0] spk_r_q,
  output logic [7:0] src_q
);
  localparam int NREG = 10;
  localparam logic [7:0] ADDR_W = {DEV_ADDR, 1'b0};

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_SUB, K_DATA} kind_t;

  function automatic logic [7:0] dflt(input int i);
    case (i)
      0: return ATT_RST;
      1: return MODE_RST;
      2: return PHASE_RST;
      3: return BASS_RST;
      4: return TREBLE_RST;
      5: return SPK_RST;
      6: return SPK_RST;
      9: return SRC_RST;
      default: return 8'h00;
    endcase
  endfunction

  logic [1:0] s1, s2, filt, filt_d;
  logic [FILT-1:0] h_scl, h_sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11;
      h_scl <= '1; h_sda <= '1;
      filt <= 2'b11; filt_d <= 2'b11;
    end else begin
      s1 <= {sda_i, scl_i};
      s2 <= s1;
      h_scl <= {h_scl[FILT-2:0], s2[0]};
      h_sda <= {h_sda[FILT-2:0], s2[1]};
      if (&h_scl) filt[0] <= 1'b1; else if (~|h_scl) filt[0] <= 1'b0;
      if (&h_sda) filt[1] <= 1'b1; else if (~|h_sda) filt[1] <= 1'b0;
      filt_d <= filt;
    end
  end

  wire scl_rise = filt[0] & ~filt_d[0];
  wire scl_fall = ~filt[0] & filt_d[0];
  wire scl_held = filt[0] & filt_d[0];
  wire start_c  = scl_held & filt_d[1] & ~filt[1];
  wire stop_c   = scl_held & ~filt_d[1] & filt[1];

  st_t        st;
  kind_t      kind;
  logic [3:0] cnt, ptr;
  logic [7:0] sh;
  logic       auto_inc, pull;
  logic [7:0] bank [NREG];

  wire wr_ok = (int'(ptr) < NREG) && (ptr != 4'd7) && (ptr != 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_ADDR;
      cnt <= '0; ptr <= '0; sh <= '0;
      auto_inc <= 1'b0; pull <= 1'b0;
      upd_stb <= 1'b0; upd_idx <= '0;
      for (int i = 0; i < NREG; i++) bank[i] <= dflt(i);
    end else begin
      upd_stb <= 1'b0;
      if (start_c) begin
        st <= ST_RX; kind <= K_ADDR; cnt <= '0; pull <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; pull <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], filt[1]};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (kind == K_ADDR && sh != ADDR_W) begin
                st <= ST_IDLE;
              end else begin
                st   <= ST_ACK;
                pull <= 1'b1;
                if (kind == K_SUB) begin
                  ptr      <= sh[3:0];
                  auto_inc <= sh[7];
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_rise && kind == K_DATA) begin
              if (wr_ok) begin
                bank[ptr] <= sh;
                upd_stb   <= 1'b1;
                upd_idx   <= ptr;
              end
              if (auto_inc) ptr <= ptr + 4'd1;
            end else if (scl_fall) begin
              pull <= 1'b0;
              st   <= ST_RX;
              cnt  <= '0;
              kind <= (kind == K_ADDR) ? K_SUB : K_DATA;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_n = ~pull;
  assign att_q    = bank[0];
  assign mode_q   = bank[1];
  assign phase_q  = bank[2];
  assign bass_q   = bank[3];
  assign treble_q = bank[4];
  assign spk_l_q  = bank[5];
  assign spk_r_q  = bank[6];
  assign src_q    = bank[9];
endmodule

// File: rtl/tone_ctl_i2c_regs_chk.sv
module tone_ctl_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_pull_n,
  input logic       upd_stb,
  input logic [3:0] upd_idx,
  input logic [7:0] treble_q
);
  assert_stb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  assert_stb_in_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> !sda_pull_n);

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> (upd_idx <= 4'd9));

  assert_no_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> (upd_idx != 4'd7 && upd_idx != 4'd8));

  assert_treble_by_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(treble_q) |-> (upd_stb && upd_idx == 4'd4));
endmodule

bind tone_ctl_i2c_regs tone_ctl_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_n(sda_pull_n),
  .upd_stb(upd_stb), .upd_idx(upd_idx), .treble_q(treble_q)
);

// File: tb/test_tone_ctl_i2c_regs.sv
module test_tone_ctl_i2c_regs;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull_n, upd_stb;
  logic [3:0] upd_idx;
  logic [7:0] att_q, mode_q, phase_q, bass_q, treble_q, spk_l_q, spk_r_q, src_q;
  wire sda_bus = m_sda & sda_pull_n;

  always #4 clk = ~clk;

  tone_ctl_i2c_regs i_tone_ctl_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_n(sda_pull_n), .upd_stb(upd_stb), .upd_idx(upd_idx),
    .att_q(att_q), .mode_q(mode_q), .phase_q(phase_q), .bass_q(bass_q),
    .treble_q(treble_q), .spk_l_q(spk_l_q), .spk_r_q(spk_r_q), .src_q(src_q)
  );

  typedef struct packed {
    logic [79:0] regs;
    logic        ack;
    logic        stb;
    logic [3:0]  idx;
  } snap_t;

  snap_t hq[$];
  logic [7:0] exp_now [10];
  logic [7:0] dq[$];
  logic exp_ack = 1'b0;
  logic [3:0] pend_idx = 4'd0;
  int pend_req = 0;
  int pend_seen = 0;
  int ncmp = 0;
  int nbad = 0;
  string cur_req = "R1";

  function automatic logic [7:0] dut_reg(input int i);
    case (i)
      0: return att_q;
      1: return mode_q;
      2: return phase_q;
      3: return bass_q;
      4: return treble_q;
      5: return spk_l_q;
      6: return spk_r_q;
      default: return src_q;
    endcase
  endfunction

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    ncmp++;
    if (ok !== 1'b1) begin
      nbad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    snap_t s;
    for (int i = 0; i < 10; i++) s.regs[i*8 +: 8] = exp_now[i];
    s.ack = exp_ack;
    s.stb = (pend_req != pend_seen);
    s.idx = pend_idx;
    pend_seen = pend_req;
    hq.push_front(s);
    if (hq.size() > 8) void'(hq.pop_back());
  end

  always @(negedge clk) begin
    if (rst_n && hq.size() >= 7) begin
      snap_t e;
      e = hq[6];
      for (int i = 0; i < 10; i++)
        if (i != 7 && i != 8)
          chk(dut_reg(i) === e.regs[i*8 +: 8], $sformatf("reg code %0d", i),
              int'(dut_reg(i)), int'(e.regs[i*8 +: 8]));
      chk(sda_pull_n === !e.ack, "sda_pull_n", int'(sda_pull_n), int'(!e.ack));
      chk(upd_stb === e.stb, "upd_stb", int'(upd_stb), int'(e.stb));
      if (e.stb) chk(upd_idx === e.idx, "upd_idx", int'(upd_idx), int'(e.idx));
    end
  end

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw();
    m_scl = 1'b1; hw();
    m_sda = 1'b0; hw();
    m_scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw();
    m_scl = 1'b1; hw();
    m_sda = 1'b1; hw();
  endtask

  task automatic put_byte(input logic [7:0] b, input logic acked, input logic wr,
                          input logic [3:0] idx, input logic glitch);
    for (int k = 7; k >= 0; k--) begin
      m_sda = b[k];
      if (glitch && k == 4) begin
        repeat (4) @(negedge clk); m_scl = 1'b1;
        repeat (2) @(negedge clk); m_scl = 1'b0;
      end
      hw();
      m_scl = 1'b1;
      if (glitch && b[k]) begin
        repeat (4) @(negedge clk); m_sda = 1'b0;
        repeat (2) @(negedge clk); m_sda = 1'b1;
      end
      hw();
      m_scl = 1'b0;
      if (k == 0) exp_ack = acked;
    end
    m_sda = 1'b1;
    hw();
    m_scl = 1'b1;
    if (wr) begin
      exp_now[idx] = b;
      pend_idx = idx;
      pend_req++;
    end
    hw();
    m_scl = 1'b0;
    exp_ack = 1'b0;
    hw();
  endtask

  task automatic add(input logic [7:0] v);
    dq.push_back(v);
  endtask

  task automatic xfer(input logic [7:0] addr, input logic [7:0] sub,
                      input logic glitch, input logic stop);
    logic hit;
    logic ok;
    logic [3:0] p;
    hit = (addr == 8'h80);
    p = sub[3:0];
    bus_start();
    put_byte(addr, hit, 1'b0, 4'd0, 1'b0);
    put_byte(sub, hit, 1'b0, 4'd0, 1'b0);
    foreach (dq[n]) begin
      ok = hit && (p < 4'd10) && (p != 4'd7) && (p != 4'd8);
      put_byte(dq[n], hit, ok, p, glitch);
      if (sub[7]) p = p + 4'd1;
    end
    dq.delete();
    if (stop) bus_stop();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    ncmp++;
    nbad++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_run();
  end

  initial begin
    exp_now[0] = 8'h7F; exp_now[1] = 8'h6E; exp_now[2] = 8'h00;
    exp_now[3] = 8'h0F; exp_now[4] = 8'h7E; exp_now[5] = 8'h78;
    exp_now[6] = 8'h78; exp_now[7] = 8'h00; exp_now[8] = 8'h00;
    exp_now[9] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    cur_req = "R1";
    chk(att_q === 8'h7F, "reset att_q", int'(att_q), 'h7F);
    chk(mode_q === 8'h6E, "reset mode_q", int'(mode_q), 'h6E);
    chk(treble_q === 8'h7E, "reset treble_q", int'(treble_q), 'h7E);
    chk(spk_l_q === 8'h78, "reset spk_l_q", int'(spk_l_q), 'h78);
    chk(spk_r_q === 8'h78, "reset spk_r_q", int'(spk_r_q), 'h78);
    chk(src_q === 8'h00, "reset src_q", int'(src_q), 'h00);
    chk(sda_pull_n === 1'b1, "reset sda_pull_n", int'(sda_pull_n), 1);

    cur_req = "R5";
    add(8'h12); add(8'h34); add(8'h56);
    xfer(8'h80, 8'h04, 1'b0, 1'b1);
    chk(treble_q === 8'h56, "single-mode last byte", int'(treble_q), 'h56);

    cur_req = "R4";
    add(8'hA5); add(8'h5A);
    xfer(8'h80, 8'h73, 1'b0, 1'b1);
    chk(bass_q === 8'h5A, "select bits 6:4 ignored", int'(bass_q), 'h5A);

    cur_req = "R6";
    add(8'h01); add(8'h02); add(8'h03); add(8'h04);
    add(8'h05); add(8'h06); add(8'h07);
    xfer(8'h80, 8'h80, 1'b0, 1'b1);
    chk(spk_r_q === 8'h07, "auto-increment reaches code 6", int'(spk_r_q), 'h07);

    cur_req = "R8";
    add(8'hC6); add(8'hC7); add(8'hC8); add(8'hC9);
    xfer(8'h80, 8'h86, 1'b0, 1'b1);
    chk(src_q === 8'hC9, "fourth byte lands on code 9", int'(src_q), 'hC9);

    cur_req = "R7";
    add(8'hEE); add(8'hEF); add(8'hE0); add(8'hE1);
    xfer(8'h80, 8'h8E, 1'b0, 1'b1);
    chk(att_q === 8'hE0, "wrap to code 0", int'(att_q), 'hE0);
    add(8'h99); add(8'h98);
    xfer(8'h80, 8'h0B, 1'b0, 1'b1);

    cur_req = "R3";
    add(8'h44); add(8'h45);
    xfer(8'h82, 8'h04, 1'b0, 1'b1);
    add(8'h46);
    xfer(8'h81, 8'h02, 1'b0, 1'b1);
    chk(phase_q === 8'h03, "no store after wrong address", int'(phase_q), 'h03);

    cur_req = "R11";
    add(8'h3C);
    xfer(8'h80, 8'h03, 1'b0, 1'b0);
    add(8'h77);
    xfer(8'h90, 8'h03, 1'b0, 1'b0);
    add(8'h5D);
    xfer(8'h80, 8'h09, 1'b0, 1'b1);
    chk(bass_q === 8'h3C, "wrong address after repeated START ignored", int'(bass_q), 'h3C);
    chk(src_q === 8'h5D, "good address after repeated START", int'(src_q), 'h5D);

    cur_req = "R10";
    add(8'hB7); add(8'h6D);
    xfer(8'h80, 8'h82, 1'b1, 1'b1);
    chk(phase_q === 8'hB7, "glitched byte to code 2", int'(phase_q), 'hB7);
    chk(bass_q === 8'h6D, "glitched byte to code 3", int'(bass_q), 'h6D);

    cur_req = "R2";
    add(8'h2B);
    xfer(8'h80, 8'h05, 1'b0, 1'b1);

    cur_req = "R9";
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule